// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Register Writes

This block drives 32 general-purpose pins grouped into two banks of 16. Each bank owns eight per-pin control words (output level, output drive enable, open-drain mode, output inversion, pull-up request, pull-down request, input enable, input inversion) and one read-only word that returns the conditioned input level. The second bank repeats the first bank's layout 0x80 bytes higher in the address space.

Software updates any control word with a single 32-bit write. The low half names pins whose feature is switched on, and the high half names pins whose feature is switched off. Pins with neither bit set keep their state, so two agents can change different pins of one word without a read-modify-write race. Reads return the 16 feature bits together with their complement, so a driver can check the encoding.

At the pad side the block produces a data level, a drive enable and two pull request flags for each pin. Incoming pad levels pass through a two-stage synchroniser and the optional inversion before they reach the read-only word.

Top module: `gpioSetClrBank`

## Requirements
- R1: After reset every control feature of every pin is off. padOe is all zero, and a read of any control word returns 0xFFFF0000.
- R2: In a write to a control word, data bit n (0..15) switches the feature on for pin n of that bank, and data bit n+16 switches it off. Pins with both bits 0 keep their state.
- R3: When one write has both the on bit and the off bit of the same pin at 1, the feature ends up off.
- R4: Byte offsets 0x00-0x7F address the bank for pins 0..15. The same offsets plus 0x80 address the bank for pins 16..31.
- R5: The in-bank byte offsets are: output level 0x00, drive enable 0x04, open-drain 0x08, output invert 0x0C, pull-up 0x18, pull-down 0x1C, input enable 0x20, input invert 0x24, read-back 0x30.
- R6: A control-word read returns the 16 feature bits in bits 15:0 and their bitwise complement in bits 31:16.
- R7: For a pin with open-drain off: padOe equals its drive enable, and padOut equals output level XOR output invert.
- R8: For a pin with open-drain on: padOut is 0, and padOe is 1 only when drive enable is 1 and output level XOR output invert is 0.
- R9: pullUpEn and pullDnEn show, per pin, the pull-up and pull-down feature bits.
- R10: Read-back bit n is (padIn after two clock stages) XOR input invert, forced to 0 when input enable is off. The upper 16 read bits are 0. A pad change made before edge k is visible to a read sampled at edge k+2 and not to one sampled at edge k+1.
- R11: Writes to the read-back offset, to unassigned offsets (including 0x10, 0x40) and to addresses whose low two bits are not 0 change no state. Reads of these addresses other than read-back return 0.
- R12: rdData takes the addressed value at the clock edge that samples rdEn=1, and holds it while rdEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address of the register |
| wrData | input | 32 | Write word: on bits in 15:0, off bits in 31:16 |
| rdData | output | 32 | Registered read word |
| padIn | input | 32 | Asynchronous pad input levels |
| padOut | output | 32 | Pad output level |
| padOe | output | 32 | Pad drive enable |
| pullUpEn | output | 32 | Pull-up request per pin |
| pullDnEn | output | 32 | Pull-down request per pin |

## Verification
The bench builds the block with its defaults: 16 pins per bank, two banks, a 0x80 bank stride and an 8-bit address. With these values both banks and the bank boundary at 0x80 are reachable, as are unassigned offsets inside a bank. The scoreboard compares each read against a value the bench works out from the requirements, including the two-edge latency of the input synchroniser. Pad outputs are checked directly after each write, so the checks cover push-pull and open-drain driving, and also the priority of the off bit over the on bit.

// File: rtl/gpioBankPkg.sv
package gpioBankPkg;

  // Selector for one register of a bank; values 0..7 are writable control words
  typedef enum logic [3:0] {
    FEAT_OUT_VAL   = 4'd0,
    FEAT_OUT_EN    = 4'd1,
    FEAT_OD_EN     = 4'd2,
    FEAT_OUT_INV   = 4'd3,
    FEAT_PULL_UP   = 4'd4,
    FEAT_PULL_DN   = 4'd5,
    FEAT_IN_EN     = 4'd6,
    FEAT_IN_INV    = 4'd7,
    FEAT_READ_BACK = 4'd8,
    FEAT_NONE      = 4'd9
  } featSel_e;

  localparam int NUM_CTRL_FEAT = 8;
  localparam int MAX_BANK_W    = 4;

  // Strobes handed from the decoder to the register datapath
  typedef struct packed {
    logic                  wrStb;
    logic                  rdStb;
    logic [MAX_BANK_W-1:0] bankSel;
    featSel_e              feat;
  } regStrobe_t;

  // In-bank byte offset to register selector (R5)
  function automatic featSel_e decodeOffset(input int unsigned ofs);
    case (ofs)
      32'h00:  return FEAT_OUT_VAL;
      32'h04:  return FEAT_OUT_EN;
      32'h08:  return FEAT_OD_EN;
      32'h0C:  return FEAT_OUT_INV;
      32'h18:  return FEAT_PULL_UP;
      32'h1C:  return FEAT_PULL_DN;
      32'h20:  return FEAT_IN_EN;
      32'h24:  return FEAT_IN_INV;
      32'h30:  return FEAT_READ_BACK;
      default: return FEAT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpioBankCtrl.sv
module gpioBankCtrl
  import gpioBankPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_BANKS   = 2,
  parameter int BANK_STRIDE = 128
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe
);
  localparam int OFS_W  = $clog2(BANK_STRIDE);
  localparam int BANK_W = ADDR_W - OFS_W;

  logic [BANK_W-1:0] bankIdx;
  logic [OFS_W-1:0]  ofs;
  logic              bankOk;
  featSel_e          feat;

  always_comb begin
    bankIdx = addr[ADDR_W-1:OFS_W];
    ofs     = addr[OFS_W-1:0];
    bankOk  = 32'(bankIdx) < NUM_BANKS;
    feat    = bankOk ? decodeOffset(32'(ofs)) : FEAT_NONE;

    strobe.bankSel = MAX_BANK_W'(bankIdx);
    strobe.feat    = feat;
    strobe.rdStb   = rdEn;
    // read-back and unassigned offsets never produce a write strobe (R11)
    strobe.wrStb   = wrEn && (feat < FEAT_READ_BACK);
  end

endmodule

// File: rtl/gpioBankData.sv
module gpioBankData
  import gpioBankPkg::*;
#(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  regStrobe_t                           strobe,
  input  logic [2*PINS_PER_BANK-1:0]           wrData,
  output logic [2*PINS_PER_BANK-1:0]           rdData,
  input  logic [PINS_PER_BANK*NUM_BANKS-1:0]   padIn,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0]   padOut,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0]   padOe,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0]   pullUpEn,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0]   pullDnEn
);
  localparam int PINS     = PINS_PER_BANK;
  localparam int DATA_W   = 2 * PINS;
  localparam int NUM_PINS = PINS * NUM_BANKS;

  logic [PINS-1:0]     featReg  [NUM_BANKS][NUM_CTRL_FEAT];
  logic [PINS-1:0]     readBack [NUM_BANKS];
  logic [NUM_PINS-1:0] syncA, syncB;
  logic [DATA_W-1:0]   rdNext;
  logic [PINS-1:0]     setBits, clrBits;

  assign setBits = wrData[PINS-1:0];
  assign clrBits = wrData[DATA_W-1:PINS];

  // Control words: set then clear, so clear wins (R2, R3)
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int f = 0; f < NUM_CTRL_FEAT; f++) begin
        if (!rstN) begin
          featReg[b][f] <= '0;
        end else if (strobe.wrStb && 32'(strobe.bankSel) == b && 32'(strobe.feat) == f) begin
          featReg[b][f] <= (featReg[b][f] | setBits) & ~clrBits;
        end
      end
    end
  end

  // Two-stage input synchroniser (R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // Pad drive, pulls and read-back conditioning (R7, R8, R9, R10)
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic [PINS-1:0] level;
      logic [PINS-1:0] openDrain;
      level     = featReg[b][int'(FEAT_OUT_VAL)] ^ featReg[b][int'(FEAT_OUT_INV)];
      openDrain = featReg[b][int'(FEAT_OD_EN)];
      padOut[b*PINS +: PINS]   = level & ~openDrain;
      padOe[b*PINS +: PINS]    = featReg[b][int'(FEAT_OUT_EN)] & ~(openDrain & level);
      pullUpEn[b*PINS +: PINS] = featReg[b][int'(FEAT_PULL_UP)];
      pullDnEn[b*PINS +: PINS] = featReg[b][int'(FEAT_PULL_DN)];
      readBack[b] = (syncB[b*PINS +: PINS] ^ featReg[b][int'(FEAT_IN_INV)])
                    & featReg[b][int'(FEAT_IN_EN)];
    end
  end

  // Read selection (R6, R10, R11)
  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(strobe.bankSel) == b) begin
        if (strobe.feat == FEAT_READ_BACK) begin
          rdNext = {{PINS{1'b0}}, readBack[b]};
        end else begin
          for (int f = 0; f < NUM_CTRL_FEAT; f++) begin
            if (32'(strobe.feat) == f) rdNext = {~featReg[b][f], featReg[b][f]};
          end
        end
      end
    end
  end

  // Registered read port (R12)
  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdStb) rdData <= rdNext;
  end

endmodule

// File: rtl/gpioSetClrBank.sv
module gpioSetClrBank
  import gpioBankPkg::*;
#(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2,
  parameter int BANK_STRIDE   = 128,
  parameter int ADDR_W        = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic                               rdEn,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [2*PINS_PER_BANK-1:0]         wrData,
  output logic [2*PINS_PER_BANK-1:0]         rdData,
  input  logic [PINS_PER_BANK*NUM_BANKS-1:0] padIn,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0] padOut,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0] padOe,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0] pullUpEn,
  output logic [PINS_PER_BANK*NUM_BANKS-1:0] pullDnEn
);
  regStrobe_t strobe;

  gpioBankCtrl #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_STRIDE(BANK_STRIDE)
  ) uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobe(strobe)
  );

  gpioBankData #(
    .PINS_PER_BANK(PINS_PER_BANK), .NUM_BANKS(NUM_BANKS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn)
  );

endmodule

// File: rtl/gpioSetClrBankChk.sv
module gpioSetClrBankChk #(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2,
  parameter int BANK_STRIDE   = 128,
  parameter int ADDR_W        = 8
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               wrEn,
  input logic                               rdEn,
  input logic [ADDR_W-1:0]                  addr,
  input logic [2*PINS_PER_BANK-1:0]         wrData,
  input logic [2*PINS_PER_BANK-1:0]         rdData,
  input logic [PINS_PER_BANK*NUM_BANKS-1:0] padOe
);
  localparam int PINS   = PINS_PER_BANK;
  localparam int DATA_W = 2 * PINS;
  localparam int OFS_W  = $clog2(BANK_STRIDE);

  logic        bankOk, ctrlHit, rbHit, deadHit, lowOutEnWr;
  int unsigned ofs;

  always_comb begin
    bankOk     = 32'(addr[ADDR_W-1:OFS_W]) < NUM_BANKS;
    ofs        = 32'(addr[OFS_W-1:0]);
    ctrlHit    = bankOk && (ofs inside {32'h00, 32'h04, 32'h08, 32'h0C,
                                        32'h18, 32'h1C, 32'h20, 32'h24});
    rbHit      = bankOk && ofs == 32'h30;
    deadHit    = !ctrlHit && !rbHit;
    lowOutEnWr = wrEn && addr == ADDR_W'(4) && wrData != '0;
  end

  // R1: first cycle out of reset has no pad driven
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> padOe == '0);

  // R3: pins named in the off half of a drive-enable write never drive next cycle
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    lowOutEnWr |=> (padOe[PINS-1:0] & $past(wrData[DATA_W-1:PINS])) == '0);

  // R6: control reads carry a complemented upper half
  a_r6_complement: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && ctrlHit) |-> rdData[DATA_W-1:PINS] == ~rdData[PINS-1:0]);

  // R10: read-back upper half is zero
  a_r10_rb_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && rbHit) |-> rdData[DATA_W-1:PINS] == '0);

  // R11: unassigned addresses read as zero
  a_r11_dead_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && deadHit) |-> rdData == '0);

  // R12: without a read strobe the read word holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rdEn) && !$past(!rstN)) |-> $stable(rdData));

endmodule

bind gpioSetClrBank gpioSetClrBankChk #(
  .PINS_PER_BANK(PINS_PER_BANK), .NUM_BANKS(NUM_BANKS),
  .BANK_STRIDE(BANK_STRIDE), .ADDR_W(ADDR_W)
) uChk (.*);

// File: tb/gpioSetClrBank_test.sv
module gpioSetClrBank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, pullUpEn, pullDnEn;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpioSetClrBank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver tasks: called at a falling edge, return at a falling edge
  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Monitor: a read sampled at a rising edge is compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          check("scoreboard underflow", rdData, 32'hx);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1
    check("R1 padOe after reset", padOe, 32'h0);
    regRead(8'h04, 32'hFFFF0000, "R1 low drive enable after reset");
    regRead(8'h9C, 32'hFFFF0000, "R1 high pull-down after reset");

    // R2: set pins 0,2,5,7 then clear pin 0
    regWrite(8'h04, 32'h000000A5);
    check("R2 padOe after set", padOe, 32'h000000A5);
    regWrite(8'h04, 32'h00010000);
    check("R2 padOe after clear", padOe, 32'h000000A4);

    // R3: both bits on a set pin and on a clear pin
    regWrite(8'h04, 32'h00040004);
    regWrite(8'h04, 32'h00020002);
    check("R3 clear wins", padOe, 32'h000000A0);
    regRead(8'h04, 32'hFF5F00A0, "R3 R6 drive enable word");

    // R7: push-pull level with inversion
    regWrite(8'h00, 32'h00000020);
    check("R7 padOut level", padOut, 32'h00000020);
    regWrite(8'h0C, 32'h00000080);
    check("R7 padOut inverted", padOut, 32'h000000A0);
    check("R7 padOe push-pull", padOe, 32'h000000A0);

    // R8: open-drain on pins 5 and 7 (both effective level 1 -> released)
    regWrite(8'h08, 32'h000000A0);
    check("R8 released padOe", padOe, 32'h00000000);
    check("R8 padOut zero", padOut, 32'h00000000);
    regWrite(8'h00, 32'h00200000);
    check("R8 drive low padOe", padOe, 32'h00000020);
    check("R8 drive low padOut", padOut, 32'h00000000);

    // R4: high bank drive enable for pins 16,17
    regWrite(8'h84, 32'h00000003);
    check("R4 high bank padOe", padOe, 32'h00030020);
    check("R4 high bank padOut", padOut, 32'h00000000);

    // R5, R6: readback of each control word
    regRead(8'h00, 32'hFFFF0000, "R5 output level word");
    regRead(8'h08, 32'hFF5F00A0, "R5 open-drain word");
    regRead(8'h0C, 32'hFF7F0080, "R5 output invert word");
    regRead(8'h84, 32'hFFFC0003, "R4 R6 high drive enable word");

    // R12: rdData holds between reads
    repeat (3) @(negedge clk);
    check("R12 rdData held", rdData, 32'hFFFC0003);

    // R9
    regWrite(8'h18, 32'h00000001);
    regWrite(8'h9C, 32'h00008000);
    check("R9 pull-up", pullUpEn, 32'h00000001);
    check("R9 pull-down", pullDnEn, 32'h80000000);
    regRead(8'h18, 32'hFFFE0001, "R5 pull-up word");

    // R10: input path
    padIn = 32'h00010003;
    repeat (3) @(negedge clk);
    regRead(8'h30, 32'h00000000, "R10 input disabled");
    regWrite(8'h20, 32'h00000003);
    regRead(8'h30, 32'h00000003, "R10 input enabled");
    regWrite(8'h24, 32'h00000001);
    regRead(8'h30, 32'h00000002, "R10 input inverted");
    regWrite(8'hA0, 32'h00000001);
    regRead(8'hB0, 32'h00000001, "R10 R4 high bank read-back");
    padIn = 32'h00010001;
    @(negedge clk);
    regRead(8'h30, 32'h00000002, "R10 one edge not yet visible");
    regRead(8'h30, 32'h00000000, "R10 visible after two edges");

    // R11: ignored writes and zero reads
    regWrite(8'h30, 32'h0000FFFF);
    regWrite(8'h10, 32'h0000FFFF);
    regWrite(8'h40, 32'h0000FFFF);
    regWrite(8'h05, 32'h0000FFFF);
    check("R11 padOe untouched", padOe, 32'h00030020);
    check("R11 pullUpEn untouched", pullUpEn, 32'h00000001);
    check("R11 padOut untouched", padOut, 32'h00000000);
    regRead(8'h30, 32'h00000000, "R11 read-back untouched");
    regRead(8'h10, 32'h00000000, "R11 unassigned read");
    regRead(8'h06, 32'h00000000, "R11 misaligned read");
    regRead(8'h04, 32'hFF5F00A0, "R11 drive enable word untouched");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) check("scoreboard leftover", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule